// File: doc/BRIEF.md
# 8b/10b Character Decoder with Error Typing

This block sits behind the receive data-recovery path and accepts one aligned 10-bit line character on every clock, one clock being one byte period. In normal operation it turns each character into its 8-bit byte and flags whether the character was one of the twelve control symbols. It also checks that the character belongs to the legal 8b/10b code space and keeps a running disparity across the stream.

Errors come out on a single error strobe that lines up with the output byte it belongs to. A two-bit kind field next to the strobe tells a code violation apart from a disparity violation. A disparity violation is meant as a measure of link health. The byte it appears with is not necessarily the one that caused it.

A raw-mode input bypasses decoding altogether. The received 10-bit character is then passed through undecoded with one clock of delay. All outputs are registered.

Top module: `dec8b10b_rx`

## Requirements
- R1: In decode mode, `data_out[7:0]` carries the decoded byte HGFEDCBA (A at bit 0) and `data_out[9:8]` is zero, one clock after the character is presented. `char_in[9:4]` holds sub-block abcdei, with a at bit 9, and `char_in[3:0]` holds fghj, with f at bit 3.
- R2: `k_out` is high one clock later exactly when the character is a legal encoding, in either disparity form, of K28.0 to K28.7, K23.7, K27.7, K29.7 or K30.7. It is low for data characters and for code errors.
- R3: A character that encodes no data or control symbol under either running disparity gives `err_out`=1 and `err_kind`=2'b01.
- R4: A character that is legal only under the running disparity opposite to the current one gives `err_out`=1 and `err_kind`=2'b10.
- R5: For a character that is legal under the current running disparity, `err_out` is 0 and `err_kind` is 2'b00. The error strobe is therefore high only for the byte period of the offending character.
- R6: A synchronous active-low reset clears every output to zero and sets the running disparity to negative.
- R7: After every decoded character, including erroneous ones, the running disparity is updated per sub-block: first the 6-bit sub-block, then the 4-bit one. Within each sub-block the rule is as follows:
  - More ones than zeros, or the patterns 000111 and 0011, make it positive.
  - Fewer ones than zeros, or the patterns 111000 and 1100, make it negative.
  - Anything else leaves it unchanged.
- R8: When `raw_mode` is high, `data_out` equals `char_in` one clock later, `k_out` and `err_out` are 0, `err_kind` is 2'b00, and the running disparity is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte-period clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_mode | input | 1 | High: pass the character through undecoded |
| char_in | input | 10 | Received character, abcdei fghj from bit 9 down |
| data_out | output | 10 | Decoded byte (zero-extended) or raw character |
| k_out | output | 1 | Control-symbol indicator |
| err_out | output | 1 | Error strobe for this byte period |
| err_kind | output | 2 | 00 none, 01 code error, 10 disparity error |

## Verification
The decoder is exercised in four ways:
- A long random stream of correctly encoded data and control characters shows that clean traffic decodes with no false errors.
- The same stream with a fraction of characters deliberately encoded under the wrong disparity separates disparity errors from code errors.
- All 1024 possible characters are swept twice, once with the running disparity forced negative and once forced positive. This separates characters that are illegal everywhere from those that are illegal only under one disparity. It also checks how the disparity recovers after each kind of error.
- Raw-mode bursts carrying all-ones patterns, followed by decoding again, show whether the bypass leaks into the running disparity.

// File: rtl/dec8b10b_pkg.sv
// Package: shared widths, error kinds and the 8b/10b code functions.
// Assumes the sub-block bit order abcdei fghj with a as the MSB.
package dec8b10b_pkg;

    localparam int CHAR_W = 10;
    localparam int BYTE_W = 8;
    localparam int HI_W   = 6;
    localparam int LO_W   = 4;
    localparam int NUM_X  = 32;

    typedef enum logic [1:0] {
        ERR_NONE = 2'b00,
        ERR_CODE = 2'b01,
        ERR_DISP = 2'b10
    } err_kind_e;

    // 6-bit sub-block for a 5-bit value; rd_pos selects the positive-disparity form.
    function automatic logic [HI_W-1:0] enc6(input logic [4:0] x, input logic rd_pos);
        logic [HI_W-1:0] c;
        case (x)
            5'd0:  c = 6'b100111;  5'd1:  c = 6'b011101;
            5'd2:  c = 6'b101101;  5'd3:  c = 6'b110001;
            5'd4:  c = 6'b110101;  5'd5:  c = 6'b101001;
            5'd6:  c = 6'b011001;  5'd7:  c = 6'b111000;
            5'd8:  c = 6'b111001;  5'd9:  c = 6'b100101;
            5'd10: c = 6'b010101;  5'd11: c = 6'b110100;
            5'd12: c = 6'b001101;  5'd13: c = 6'b101100;
            5'd14: c = 6'b011100;  5'd15: c = 6'b010111;
            5'd16: c = 6'b011011;  5'd17: c = 6'b100011;
            5'd18: c = 6'b010011;  5'd19: c = 6'b110010;
            5'd20: c = 6'b001011;  5'd21: c = 6'b101010;
            5'd22: c = 6'b011010;  5'd23: c = 6'b111010;
            5'd24: c = 6'b110011;  5'd25: c = 6'b100110;
            5'd26: c = 6'b010110;  5'd27: c = 6'b110110;
            5'd28: c = 6'b001110;  5'd29: c = 6'b101110;
            5'd30: c = 6'b011110;  default: c = 6'b101011;
        endcase
        if (rd_pos && (($countones(c) != 3) || (x == 5'd7)))
            c = ~c;
        return c;
    endfunction

    // 4-bit sub-block for a 3-bit value; alt7 picks the alternate form of value 7.
    function automatic logic [LO_W-1:0] enc4(input logic [2:0] y, input logic rd_pos,
                                             input logic alt7);
        logic [LO_W-1:0] c;
        case (y)
            3'd0: c = 4'b1011;
            3'd1: c = 4'b1001;
            3'd2: c = 4'b0101;
            3'd3: c = 4'b1100;
            3'd4: c = 4'b1101;
            3'd5: c = 4'b1010;
            3'd6: c = 4'b0110;
            default: c = alt7 ? 4'b0111 : 4'b1110;
        endcase
        if (rd_pos && (($countones(c) != 2) || (y == 3'd3)))
            c = ~c;
        return c;
    endfunction

    // Disparity after a 6-bit sub-block, from its bit balance.
    function automatic logic end_rd6(input logic [HI_W-1:0] c, input logic rd_in);
        if (($countones(c) > 3) || (c == 6'b000111)) return 1'b1;
        if (($countones(c) < 3) || (c == 6'b111000)) return 1'b0;
        return rd_in;
    endfunction

    // Disparity after a 4-bit sub-block, from its bit balance.
    function automatic logic end_rd4(input logic [LO_W-1:0] c, input logic rd_in);
        if (($countones(c) > 2) || (c == 4'b0011)) return 1'b1;
        if (($countones(c) < 2) || (c == 4'b1100)) return 1'b0;
        return rd_in;
    endfunction

    // Full data-character encoding under a given running disparity.
    function automatic logic [CHAR_W-1:0] encode_data(input logic [BYTE_W-1:0] b,
                                                      input logic rd_pos);
        logic [4:0]      x;
        logic [2:0]      y;
        logic [HI_W-1:0] c6;
        logic            rd_mid;
        logic            alt;
        x      = b[4:0];
        y      = b[7:5];
        c6     = enc6(x, rd_pos);
        rd_mid = end_rd6(c6, rd_pos);
        alt    = (y == 3'd7) &&
                 ((!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                  ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
        return {c6, enc4(y, rd_mid, alt)};
    endfunction

    // True for the twelve byte values that have a control encoding.
    function automatic logic is_ctrl(input logic [BYTE_W-1:0] b);
        return (b[4:0] == 5'd28) ||
               ((b[7:5] == 3'd7) && (b[4:0] == 5'd23 || b[4:0] == 5'd27 ||
                                     b[4:0] == 5'd29 || b[4:0] == 5'd30));
    endfunction

    // Control-character encoding; the positive form is the complement of the negative one.
    function automatic logic [CHAR_W-1:0] encode_ctrl(input logic [BYTE_W-1:0] b,
                                                      input logic rd_pos);
        logic [LO_W-1:0]   lo;
        logic [CHAR_W-1:0] neg;
        case (b[7:5])
            3'd0: lo = 4'b0100;
            3'd1: lo = 4'b1001;
            3'd2: lo = 4'b0101;
            3'd3: lo = 4'b0011;
            3'd4: lo = 4'b0010;
            3'd5: lo = 4'b1010;
            3'd6: lo = 4'b0110;
            default: lo = 4'b1000;
        endcase
        if (b[4:0] == 5'd28) neg = {6'b001111, lo};
        else                 neg = {enc6(b[4:0], 1'b0), 4'b1000};
        return rd_pos ? ~neg : neg;
    endfunction

endpackage

// File: rtl/dec8b10b_split.sv
// Module: proposes the byte a character stands for by decoding each
// sub-block on its own. Assumes legality is judged elsewhere; the
// proposal is only meaningful for legal characters.
module dec8b10b_split
    import dec8b10b_pkg::*;
(
    input  logic [CHAR_W-1:0] char_in,
    output logic [BYTE_W-1:0] byte_out
);

    logic [HI_W-1:0] hi;
    logic [LO_W-1:0] lo;
    logic [LO_W-1:0] lo_norm;
    logic            k28_hi;
    logic [4:0]      x_val;
    logic [2:0]      y_val;

    assign hi      = char_in[CHAR_W-1:LO_W];
    assign lo      = char_in[LO_W-1:0];
    assign k28_hi  = (hi == 6'b001111) || (hi == 6'b110000);
    // Positive-form K28 characters carry a complemented low sub-block.
    assign lo_norm = (hi == 6'b110000) ? ~lo : lo;

    // Search the 6-bit code space in both disparity forms for the 5-bit value.
    always_comb begin
        x_val = 5'd0;
        for (int v = 0; v < NUM_X; v++) begin
            if ((hi == enc6(5'(v), 1'b0)) || (hi == enc6(5'(v), 1'b1)))
                x_val = 5'(v);
        end
        if (k28_hi)
            x_val = 5'd28;
    end

    // Map the 4-bit sub-block in either polarity to its 3-bit value.
    always_comb begin
        case (lo_norm)
            4'b1011, 4'b0100:                   y_val = 3'd0;
            4'b1001:                            y_val = 3'd1;
            4'b0101:                            y_val = 3'd2;
            4'b1100, 4'b0011:                   y_val = 3'd3;
            4'b1101, 4'b0010:                   y_val = 3'd4;
            4'b1010:                            y_val = 3'd5;
            4'b0110:                            y_val = 3'd6;
            4'b1110, 4'b0001, 4'b0111, 4'b1000: y_val = 3'd7;
            default:                            y_val = 3'd0;
        endcase
    end

    assign byte_out = {y_val, x_val};

endmodule

// File: rtl/dec8b10b_legal.sv
// Module: judges a character by re-encoding the proposed byte under both
// running disparities and comparing. Assumes rd_pos is the current disparity.
module dec8b10b_legal
    import dec8b10b_pkg::*;
(
    input  logic [CHAR_W-1:0] char_in,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              rd_pos,
    output logic              is_k,
    output logic              legal_any,
    output logic              legal_now
);

    localparam int NUM_RD = 2;

    logic [NUM_RD-1:0] data_hit;
    logic [NUM_RD-1:0] ctrl_hit;

    // One comparison pair per running-disparity polarity.
    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        assign data_hit[r] = (char_in == encode_data(byte_in, 1'(r)));
        assign ctrl_hit[r] = is_ctrl(byte_in) && (char_in == encode_ctrl(byte_in, 1'(r)));
    end

    assign is_k      = |ctrl_hit;
    assign legal_any = |data_hit || |ctrl_hit;
    assign legal_now = data_hit[rd_pos] || ctrl_hit[rd_pos];

endmodule

// File: rtl/dec8b10b_rdnext.sv
// Module: next running disparity from the received bits alone, applied to
// the 6-bit sub-block first and then the 4-bit one. Valid for illegal input too.
module dec8b10b_rdnext
    import dec8b10b_pkg::*;
(
    input  logic [CHAR_W-1:0] char_in,
    input  logic              rd_pos,
    output logic              rd_next
);

    logic rd_mid;

    assign rd_mid  = end_rd6(char_in[CHAR_W-1:LO_W], rd_pos);
    assign rd_next = end_rd4(char_in[LO_W-1:0], rd_mid);

endmodule

// File: rtl/dec8b10b_rx.sv
// Module: top of the 8b/10b receive decoder. One character per clock in,
// registered byte, control flag and typed error out one clock later.
// Assumes characters arrive already aligned to their 10-bit boundaries.
module dec8b10b_rx
    import dec8b10b_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_mode,
    input  logic [CHAR_W-1:0] char_in,
    output logic [CHAR_W-1:0] data_out,
    output logic              k_out,
    output logic              err_out,
    output logic [1:0]        err_kind
);

    logic [BYTE_W-1:0] dec_byte;
    logic              is_k;
    logic              legal_any;
    logic              legal_now;
    logic              rd_next;
    logic              run_disp;
    err_kind_e         kind_nxt;

    dec8b10b_split u_split (
        .char_in  (char_in),
        .byte_out (dec_byte)
    );

    dec8b10b_legal u_legal (
        .char_in   (char_in),
        .byte_in   (dec_byte),
        .rd_pos    (run_disp),
        .is_k      (is_k),
        .legal_any (legal_any),
        .legal_now (legal_now)
    );

    dec8b10b_rdnext u_rdnext (
        .char_in (char_in),
        .rd_pos  (run_disp),
        .rd_next (rd_next)
    );

    // Classify the character: code violation wins over disparity violation.
    always_comb begin
        if (!legal_any)      kind_nxt = ERR_CODE;
        else if (!legal_now) kind_nxt = ERR_DISP;
        else                 kind_nxt = ERR_NONE;
    end

    // Register outputs and running disparity; bypass holds the disparity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
            k_out    <= 1'b0;
            err_out  <= 1'b0;
            err_kind <= ERR_NONE;
            run_disp <= 1'b0;
        end else if (raw_mode) begin
            data_out <= char_in;
            k_out    <= 1'b0;
            err_out  <= 1'b0;
            err_kind <= ERR_NONE;
        end else begin
            data_out <= {{(CHAR_W-BYTE_W){1'b0}}, dec_byte};
            k_out    <= is_k;
            err_out  <= !legal_now;
            err_kind <= kind_nxt;
            run_disp <= rd_next;
        end
    end

endmodule

// File: rtl/dec8b10b_rx_chk.sv
// Module: property checker for dec8b10b_rx, attached with bind below.
// Assumes it sees the top's ports plus the running-disparity register.
module dec8b10b_rx_chk
    import dec8b10b_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              raw_mode,
    input logic [CHAR_W-1:0] char_in,
    input logic [CHAR_W-1:0] data_out,
    input logic              k_out,
    input logic              err_out,
    input logic [1:0]        err_kind,
    input logic              run_disp
);

    AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(raw_mode) |-> data_out == $past(char_in)); // R8

    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(raw_mode) |-> !err_out && !k_out); // R8

    AST_BYPASS_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(raw_mode) |-> run_disp == $past(run_disp)); // R8

    AST_DECODE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(raw_mode) |-> data_out[CHAR_W-1:BYTE_W] == '0); // R1

    AST_ERR_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        err_out |-> (err_kind == ERR_CODE) || (err_kind == ERR_DISP)); // R5

    AST_NO_KIND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !err_out |-> err_kind == ERR_NONE); // R5

    AST_K_NOT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        k_out |-> err_kind != ERR_CODE); // R2

    AST_RD_START_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !run_disp); // R6

    AST_RD_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(raw_mode) && ($past(char_in) == '1) |-> run_disp); // R7

    AST_RD_ALL_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(raw_mode) && ($past(char_in) == '0) |-> !run_disp); // R7

endmodule

bind dec8b10b_rx dec8b10b_rx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_mode (raw_mode),
    .char_in  (char_in),
    .data_out (data_out),
    .k_out    (k_out),
    .err_out  (err_out),
    .err_kind (err_kind),
    .run_disp (run_disp)
);

// File: tb/dec8b10b_rx_tb.sv
// Bench: behavioural reference built from lookup arrays of every legal
// character, compared against the decoder on every clock.
module dec8b10b_rx_tb;

    localparam int CLK_P    = 10;
    localparam int WD_LIMIT = 100000;

    localparam logic [5:0] T6 [32] = '{
        6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
        6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
        6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011,
        6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
        6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
        6'b011110, 6'b101011};
    localparam logic [3:0] T4 [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100,
                                      4'b1101, 4'b1010, 4'b0110, 4'b1110};
    localparam logic [3:0] K4 [8] = '{4'b0100, 4'b1001, 4'b0101, 4'b0011,
                                      4'b0010, 4'b1010, 4'b0110, 4'b1000};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw_mode = 1'b0;
    logic [9:0] char_in = '0;
    logic [9:0] data_out;
    logic       k_out;
    logic       err_out;
    logic [1:0] err_kind;

    int n_tests = 0;
    int n_fail  = 0;

    bit         ok_tab [1024][2];
    logic [7:0] byte_tab [1024];
    bit         k_tab [1024];

    bit         m_rd = 1'b0;
    logic [9:0] exp_data = '0;
    bit         exp_k = 1'b0;
    logic [1:0] exp_kind = 2'b00;
    bit         exp_byp = 1'b0;
    bit         in_reset = 1'b1;

    always #(CLK_P/2) clk = ~clk;

    dec8b10b_rx u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_mode (raw_mode),
        .char_in  (char_in),
        .data_out (data_out),
        .k_out    (k_out),
        .err_out  (err_out),
        .err_kind (err_kind)
    );

    function automatic int ones(input logic [9:0] v, input int w);
        int n = 0;
        for (int i = 0; i < w; i++) n += v[i];
        return n;
    endfunction

    function automatic bit rd_after(input logic [9:0] c, input bit rd);
        bit r = rd;
        int h = ones({4'b0, c[9:4]}, 6);
        int l = ones({6'b0, c[3:0]}, 4);
        if (h > 3 || c[9:4] == 6'b000111) r = 1'b1;
        else if (h < 3 || c[9:4] == 6'b111000) r = 1'b0;
        if (l > 2 || c[3:0] == 4'b0011) r = 1'b1;
        else if (l < 2 || c[3:0] == 4'b1100) r = 1'b0;
        return r;
    endfunction

    function automatic logic [9:0] benc(input logic [7:0] b, input bit ctrl, input bit rd);
        logic [5:0] s6;
        logic [3:0] s4;
        int x = int'(b[4:0]);
        int y = int'(b[7:5]);
        bit mid;
        bit alt;
        if (ctrl) begin
            s6 = (x == 28) ? 6'b001111 : T6[x];
            s4 = (x == 28) ? K4[y] : 4'b1000;
            return rd ? ~{s6, s4} : {s6, s4};
        end
        s6 = T6[x];
        if (rd && (ones({4'b0, s6}, 6) != 3 || x == 7)) s6 = ~s6;
        mid = rd_after({s6, 4'b1010}, rd);
        alt = (y == 7) && ((!mid && (x == 17 || x == 18 || x == 20)) ||
                           (mid && (x == 11 || x == 13 || x == 14)));
        s4 = alt ? 4'b0111 : T4[y];
        if (mid && (ones({6'b0, s4}, 4) != 2 || y == 3)) s4 = ~s4;
        return {s6, s4};
    endfunction

    function automatic bit ctrl_ok(input logic [7:0] b);
        int x = int'(b[4:0]);
        return x == 28 || (b[7:5] == 3'd7 && (x == 23 || x == 27 || x == 29 || x == 30));
    endfunction

    task automatic build_tables();
        for (int c = 0; c < 1024; c++) begin
            ok_tab[c][0] = 1'b0; ok_tab[c][1] = 1'b0;
            byte_tab[c] = '0; k_tab[c] = 1'b0;
        end
        for (int b = 0; b < 256; b++) begin
            for (int r = 0; r < 2; r++) begin
                int c = int'(benc(8'(b), 1'b0, r[0]));
                ok_tab[c][r] = 1'b1; byte_tab[c] = 8'(b); k_tab[c] = 1'b0;
                if (ctrl_ok(8'(b))) begin
                    c = int'(benc(8'(b), 1'b1, r[0]));
                    ok_tab[c][r] = 1'b1; byte_tab[c] = 8'(b); k_tab[c] = 1'b1;
                end
            end
        end
    endtask

    task automatic model_apply(input logic [9:0] c, input bit byp);
        exp_byp = byp;
        if (byp) begin
            exp_data = c; exp_k = 1'b0; exp_kind = 2'b00;
            return;
        end
        if (!(ok_tab[c][0] || ok_tab[c][1])) begin
            exp_kind = 2'b01; exp_k = 1'b0;
        end else begin
            exp_kind = ok_tab[c][m_rd] ? 2'b00 : 2'b10;
            exp_k = k_tab[c];
        end
        exp_data = {2'b00, byte_tab[c]};
        m_rd = rd_after(c, m_rd);
    endtask

    task automatic fail_line(input string tag, input string what,
                             input logic [9:0] got, input logic [9:0] want);
        n_fail++;
        $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, want, $time);
    endtask

    task automatic compare();
        string tk;
        if (exp_kind == 2'b01)      tk = "R3";
        else if (exp_kind == 2'b10) tk = "R4";
        else if (exp_byp)           tk = "R8";
        else                        tk = "R5";
        n_tests++;
        if (err_out !== (exp_kind != 2'b00) || err_kind !== exp_kind)
            fail_line(tk, "err_out/err_kind", {7'b0, err_out, err_kind},
                      {7'b0, exp_kind != 2'b00, exp_kind});
        n_tests++;
        if (k_out !== exp_k)
            fail_line(exp_byp ? "R8" : "R2", "k_out", {9'b0, k_out}, {9'b0, exp_k});
        if (exp_kind != 2'b01) begin
            n_tests++;
            if (data_out !== exp_data)
                fail_line(exp_byp ? "R8" : "R1", "data_out", data_out, exp_data);
        end
    endtask

    task automatic step(input logic [9:0] c, input bit byp);
        @(negedge clk);
        if (!in_reset) compare();
        char_in  = c;
        raw_mode = byp;
        model_apply(c, byp);
    endtask

    task automatic hard_check(input string tag, input logic [9:0] d, input bit chk_d,
                              input bit k, input logic [1:0] kind);
        @(posedge clk);
        #1;
        n_tests++;
        if ((chk_d && data_out !== d) || k_out !== k || err_kind !== kind ||
            err_out !== (kind != 2'b00))
            fail_line(tag, "directed {k,err,kind,data}",
                      {k_out, err_out, err_kind, chk_d ? data_out[5:0] : 6'b0},
                      {k, kind != 2'b00, kind, chk_d ? d[5:0] : 6'b0});
        if (chk_d && data_out !== d) fail_line(tag, "directed data", data_out, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        if (!in_reset) compare();
        in_reset = 1'b1;
        rst_n    = 1'b0;
        raw_mode = 1'b0;
        char_in  = '0;
        repeat (3) begin
            @(negedge clk);
            n_tests++;
            if (data_out !== '0 || k_out !== 1'b0 || err_out !== 1'b0 || err_kind !== 2'b00)
                fail_line("R6", "outputs in reset", data_out, 10'h000);
        end
        rst_n    = 1'b1;
        in_reset = 1'b0;
        m_rd     = 1'b0;
        model_apply(char_in, raw_mode);
    endtask

    task automatic run_stream(input int n, input int wrong_pct);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = 8'($urandom_range(0, 255));
            bit ctrl = 1'b0;
            bit rd_use = m_rd;
            if ($urandom_range(0, 9) == 0) begin
                int sel = $urandom_range(0, 11);
                ctrl = 1'b1;
                if (sel < 8) b = {3'(sel), 5'd28};
                else begin
                    case (sel)
                        8:       b = {3'd7, 5'd23};
                        9:       b = {3'd7, 5'd27};
                        10:      b = {3'd7, 5'd29};
                        default: b = {3'd7, 5'd30};
                    endcase
                end
            end
            if ($urandom_range(0, 99) < wrong_pct) rd_use = !m_rd;
            step(benc(b, ctrl, rd_use), 1'b0);
        end
    endtask

    initial begin : watchdog
        repeat (WD_LIMIT) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        build_tables();
        do_reset();

        // R1 R2 R6: first character after reset decoded under negative disparity.
        step(10'b0011111010, 1'b0);
        hard_check("R6", 10'h0BC, 1'b1, 1'b1, 2'b00);
        // R4 R7: same negative-form control character now arrives at positive disparity.
        step(10'b0011111010, 1'b0);
        hard_check("R4", 10'h0BC, 1'b1, 1'b1, 2'b10);
        // R3: all-zero character is outside the code space.
        step(10'b0000000000, 1'b0);
        hard_check("R3", 10'h000, 1'b0, 1'b0, 2'b01);
        // R7 R5: disparity went negative from the zeros; K23.7 negative form is clean.
        step(10'b1110101000, 1'b0);
        hard_check("R7", 10'h0F7, 1'b1, 1'b1, 2'b00);
        // R8: raw pass-through of an all-ones character.
        step(10'b1111111111, 1'b1);
        hard_check("R8", 10'h3FF, 1'b1, 1'b0, 2'b00);
        // R8: disparity held negative across bypass.
        step(10'b0011111010, 1'b0);
        hard_check("R8", 10'h0BC, 1'b1, 1'b1, 2'b00);
        // R3: legal sub-blocks in an illegal pairing.
        step(10'b0111100111, 1'b0);
        hard_check("R3", 10'h000, 1'b0, 1'b0, 2'b01);

        // R1 R2 R5: clean encoded traffic.
        run_stream(3000, 0);
        // R4 R7: traffic with wrong-disparity characters mixed in.
        run_stream(3000, 8);

        // R3 R4 R7: every character under both starting disparities.
        for (int t = 0; t < 2; t++) begin
            for (int c = 0; c < 1024; c++) begin
                if (m_rd == t[0]) step(10'b1010101010, 1'b0);
                else              step(m_rd ? 10'b1100000101 : 10'b0011111010, 1'b0);
                step(10'(c), 1'b0);
            end
        end

        // R8: bypass bursts interleaved with decoding.
        for (int i = 0; i < 400; i++) begin
            bit byp = ($urandom_range(0, 1) == 1);
            if (byp) step(($urandom_range(0, 3) == 0) ? 10'h3FF : 10'($urandom_range(0, 1023)), 1'b1);
            else     step(benc(8'($urandom_range(0, 255)), 1'b0, m_rd), 1'b0);
        end

        // R6: reset mid-stream returns disparity to negative.
        run_stream(50, 0);
        do_reset();
        step(10'b1100000101, 1'b0);
        hard_check("R6", 10'h0BC, 1'b1, 1'b1, 2'b10);
        run_stream(200, 5);

        @(negedge clk);
        compare();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule